// File: doc/BRIEF.md
# PLL Phase-Step Sequencer

This block sits in the fabric next to a PLL and turns a single request from user logic into the pulse train that the PLL's run-time phase-adjust port expects. A request carries three things: which PLL output to move, the direction of the move, and how many phase steps to apply. The PLL advances one step for each pulse it receives, so the block issues exactly that many pulses.

Once a request is accepted, the block drives the select and direction lines and holds them steady. It then waits a setup interval before the first pulse. Each pulse is held high for a minimum width and followed by a low gap of the same length. Every timing limit is converted at elaboration time into a whole number of controller clock cycles, rounded up from the clock frequencies. The requester sees a busy flag for the whole job and a single-cycle done pulse at its end.

Top module: `phase_step_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, busy, done and ps_step are low and ps_sel and ps_dir are 0.
- R2: A request is taken only at a clock edge where req_valid is high and busy is low. A request presented while busy is high has no effect on the running job or on ps_sel and ps_dir.
- R3: ps_sel and ps_dir take the request's select and direction from the cycle after acceptance. They keep those values unchanged until the next accepted request. The encoding passes straight through: select 2'b00 names the first secondary output, and direction 0 means lagging while 1 means leading.
- R4: For a non-zero step count, the cycle after acceptance starts a setup window of SETUP_CYC cycles, with busy high and ps_step low, before the first pulse rises. SETUP_CYC is ceil(SETUP_NS*CLK_MHZ/1000), and is at least 1.
- R5: Each pulse on ps_step stays high for exactly PULSE_CYC cycles. PULSE_CYC is ceil(PULSE_VCO*CLK_MHZ/VCO_MHZ), and is at least 1.
- R6: Consecutive pulses are separated by exactly PULSE_CYC low cycles.
- R7: The number of pulses in a job equals the accepted step count.
- R8: done is high for exactly one cycle, directly after the last pulse's final high cycle, with busy still high. busy is low in the cycle that follows.
- R9: A step count of zero gives a done cycle directly after acceptance and produces no pulse.
- R10: busy is high from the cycle after acceptance through the done cycle, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 2 | PLL output to shift |
| req_dir | input | 1 | 0 lag, 1 lead |
| req_steps | input | STEP_W | Number of phase steps |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| ps_sel | output | 2 | Output select to PLL |
| ps_dir | output | 1 | Direction to PLL |
| ps_step | output | 1 | Step pulse to PLL |

## Verification
The bench tries four kinds of job: a single step, several steps, a step count of zero, and jobs whose request strobe stays high across the whole run while the select and direction change. The single-step job isolates the setup window and the done placement. The multi-step jobs expose errors in the high time, the gap and the pulse count. The zero-count job shows whether the setup and pulse path is skipped. The held strobe with changing fields shows whether requests are ignored while busy, whether latched values leak through, and whether a new job is accepted right after the idle cycle.

// File: rtl/phstep_pkg.sv
// Shared types and elaboration helpers for the phase-step sequencer.
// Assumes all frequency and time arguments are positive integers.
package phstep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_GAP,
        ST_DONE
    } phstep_state_t;

    // Integer division rounded toward positive infinity.
    function automatic int ceil_div(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    // Clamp a cycle count so that it is never below one.
    function automatic int at_least_one(input int v);
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/phstep_timer.sv
// Down-counting interval timer. It loads a value and counts down to zero,
// then holds at zero. zero is high while the count is zero.
// Assumes load_val already includes the minus-one for an N-cycle interval.
module phstep_timer #(
    parameter int TMR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [TMR_W-1:0] load_val,
    output logic             zero
);
    logic [TMR_W-1:0] count_q;

    // Load on request, otherwise count down and saturate at zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '0;
        else if (load)
            count_q <= load_val;
        else if (count_q != '0)
            count_q <= count_q - 1'b1;
    end

    assign zero = (count_q == '0);
endmodule

// File: rtl/phstep_stepcnt.sv
// Counter for the remaining phase steps. It loads the requested count and
// decrements once per finished pulse. last is high when one step is left.
// Assumes dec is only raised while at least one step remains.
module phstep_stepcnt #(
    parameter int STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STEP_W-1:0] load_val,
    input  logic              dec,
    output logic              last
);
    logic [STEP_W-1:0] left_q;

    // Hold the number of pulses still to be issued.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (load)
            left_q <= load_val;
        else if (dec)
            left_q <= left_q - 1'b1;
    end

    assign last = (left_q == STEP_W'(1));
endmodule

// File: rtl/phase_step_seq.sv
// Phase-step sequencer top. It accepts one request when idle, latches the
// select and direction, waits a setup window, then issues the requested
// number of step pulses. Each pulse has a fixed high time and the same low
// gap between pulses, and a one-cycle done pulse ends the job.
// Assumes the PLL samples select/direction at each pulse's falling edge.
module phase_step_seq
    import phstep_pkg::*;
#(
    parameter int CLK_MHZ   = 250,
    parameter int VCO_MHZ   = 800,
    parameter int SETUP_NS  = 5,
    parameter int PULSE_VCO = 4,
    parameter int STEP_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_sel,
    input  logic              req_dir,
    input  logic [STEP_W-1:0] req_steps,
    output logic              busy,
    output logic              done,
    output logic [1:0]        ps_sel,
    output logic              ps_dir,
    output logic              ps_step
);
    localparam int SETUP_CYC = at_least_one(ceil_div(SETUP_NS * CLK_MHZ, 1000));
    localparam int PULSE_CYC = at_least_one(ceil_div(PULSE_VCO * CLK_MHZ, VCO_MHZ));
    localparam int MAX_CYC   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
    localparam int TMR_W     = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);
    localparam logic [TMR_W-1:0] SETUP_LD = TMR_W'(SETUP_CYC - 1);
    localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_CYC - 1);

    phstep_state_t    state_q, state_d;
    logic             tmr_load, tmr_zero;
    logic [TMR_W-1:0] tmr_val;
    logic             cnt_load, cnt_dec, cnt_last;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    phstep_timer #(.TMR_W(TMR_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    phstep_stepcnt #(.STEP_W(STEP_W)) u_stepcnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (req_steps),
        .dec      (cnt_dec),
        .last     (cnt_last)
    );

    // Next-state and timer/counter control.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = PULSE_LD;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    cnt_load = 1'b1;
                    if (req_steps == '0) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_SETUP;
                        tmr_load = 1'b1;
                        tmr_val  = SETUP_LD;
                    end
                end
            end
            ST_SETUP: begin
                if (tmr_zero) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_HIGH: begin
                if (tmr_zero) begin
                    cnt_dec = 1'b1;
                    if (cnt_last) begin
                        state_d = ST_DONE;
                    end else begin
                        state_d  = ST_GAP;
                        tmr_load = 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tmr_zero) begin
                    state_d  = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Select and direction latched on acceptance, held until the next one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_sel <= 2'b00;
            ps_dir <= 1'b0;
        end else if (accept) begin
            ps_sel <= req_sel;
            ps_dir <= req_dir;
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign done    = (state_q == ST_DONE);
    assign ps_step = (state_q == ST_HIGH);

    // R3
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(ps_sel) && $stable(ps_dir)));

    // R2
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && req_valid) |=> busy);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R4
    pulse_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ps_step) |-> $past(busy));

    // R8
    done_after_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ps_step) && !done) |-> busy);
endmodule

// File: tb/phase_step_seq_tb.sv
// Self-checking bench. A queue-based model predicts busy/done/ps_step for
// every cycle of a job, and the outputs are compared on every falling edge.
module phase_step_seq_tb;
    localparam int STEP_W    = 8;
    localparam int SETUP_CYC = 2;   // ceil(5*250/1000)
    localparam int PULSE_CYC = 2;   // ceil(4*250/800)

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_sel = 2'b00;
    logic              req_dir = 1'b0;
    logic [STEP_W-1:0] req_steps = '0;
    logic              busy, done, ps_dir, ps_step;
    logic [1:0]        ps_sel;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;   // 250 MHz

    phase_step_seq #(.STEP_W(STEP_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
        .req_dir(req_dir), .req_steps(req_steps), .busy(busy), .done(done),
        .ps_sel(ps_sel), .ps_dir(ps_dir), .ps_step(ps_step)
    );

    // Reference model: {busy, done, step} per cycle.
    logic [2:0] exp_q[$];
    logic [2:0] exp_cur = 3'b000;
    logic [1:0] exp_sel = 2'b00;
    logic       exp_dir = 1'b0;
    int         exp_steps = 0;
    int         seen_pulses = 0;
    logic       prev_step = 1'b0;
    logic       started = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Advance the model at each rising edge.
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            exp_q.delete();
            exp_cur = 3'b000;
            exp_sel = 2'b00;
            exp_dir = 1'b0;
        end else if (exp_q.size() != 0) begin
            exp_cur = exp_q.pop_front();
        end else if (exp_cur == 3'b000 && req_valid) begin
            exp_sel   = req_sel;
            exp_dir   = req_dir;
            exp_steps = int'(req_steps);
            if (req_steps != '0)
                for (int i = 0; i < SETUP_CYC; i++) exp_q.push_back(3'b100);
            for (int s = 0; s < int'(req_steps); s++) begin
                for (int i = 0; i < PULSE_CYC; i++) exp_q.push_back(3'b101);
                if (s != int'(req_steps) - 1)
                    for (int i = 0; i < PULSE_CYC; i++) exp_q.push_back(3'b100);
            end
            exp_q.push_back(3'b110);
            exp_cur = exp_q.pop_front();
        end else begin
            exp_cur = 3'b000;
        end
    end

    // Compare on every falling edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R10 busy", int'(busy), int'(exp_cur[2]));
            chk("R8 done", int'(done), int'(exp_cur[1]));
            chk("R5 R6 R4 R9 ps_step", int'(ps_step), int'(exp_cur[0]));
            chk("R3 R2 ps_sel", int'(ps_sel), int'(exp_sel));
            chk("R3 R2 ps_dir", int'(ps_dir), int'(exp_dir));
            if (ps_step && !prev_step) seen_pulses++;
            prev_step = ps_step;
            if (done) begin
                chk("R7 pulse count", seen_pulses, exp_steps);
                seen_pulses = 0;
            end
        end
    end

    task automatic issue(input logic [1:0] s, input logic d, input int n, input int wait_cyc);
        @(negedge clk);
        req_valid = 1'b1; req_sel = s; req_dir = d; req_steps = STEP_W'(n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (wait_cyc) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", int'(busy), 0);
        chk("R1 ps_step in reset", int'(ps_step), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 ps_sel after reset", int'(ps_sel), 0);
        issue(2'b00, 1'b0, 1, 20);      // single step, lag, first secondary output
        issue(2'b10, 1'b1, 3, 30);      // several steps, lead
        issue(2'b01, 1'b0, 0, 10);      // zero steps: R9
        // R2: strobe held high across a job with changing fields
        @(negedge clk);
        req_valid = 1'b1; req_sel = 2'b11; req_dir = 1'b1; req_steps = 8'd4;
        @(negedge clk);
        for (int i = 0; i < 40; i++) begin
            req_sel = 2'(i); req_dir = i[0]; req_steps = 8'(i % 3);
            @(negedge clk);
        end
        req_valid = 1'b0;
        repeat (30) @(negedge clk);
        issue(2'b11, 1'b0, 5, 40);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule